// File: doc/BRIEF.md
# Write-Merging Store Buffer

The block sits between a processor store port and a 64-bit system bus. Accepted stores are held in a small queue of doubleword-sized entries. A store that lands in the same aligned 8-byte block as the newest entry still open for merging is folded into that entry. The strobes are combined and the newer bytes replace the older ones. Several narrow stores therefore leave as one wide bus write. Entries drain to the bus oldest first through a valid/ready master port. No accepted byte is ever lost.

The processor reads through a lookup port. For a given address it reports which byte lanes of that block are still held in the buffer, together with the newest buffered value of each one. The read path can then overlay these bytes on data fetched from the bus. A per-store attribute marks a write as strongly ordered. Such a write gets an entry of its own and is never merged. It is issued as soon as it reaches the head of the queue, behind all earlier stores. A barrier request stalls the store port and drains the whole queue, then pulses a completion flag.

An open entry that is alone in the queue waits a short, parameterised time, so that neighbouring stores can still join it. Once that time has passed, it is sent to the bus.

Top module: `store_merge_buf`

## Requirements
- R1: A bus write carries the block's byte address (low 3 bits zero), 64 data bits and an 8-bit lane strobe where bit i enables bits 8i+7..8i. While bus_valid_o is high and bus_ready_i is low, bus_valid_o stays high and the address, data and strobe do not change.
- R2: A normal store to the same aligned 8-byte block as the newest entry joins that entry, provided the entry is not strongly ordered and is not being offered to the bus as the only entry. The strobes are ORed and the newer store's enabled bytes override. For example, four single-byte stores to lanes 0..3 become one bus write with strobe 0x0F.
- R3: Every accepted store byte reaches the bus. After a completed barrier, the image built from all bus writes equals the image built from all accepted stores.
- R4: For the block addressed by lkp_addr_i, lkp_hit_o bit i is set exactly when lane i is still held in the buffer. Where the bit is set, lane i of lkp_data_o is the value of the newest buffered store to that byte.
- R5: A strongly ordered store always takes a new entry, and no later store merges into it. It is issued in program order relative to the other entries. When it is the only entry, bus_valid_o rises in the cycle after it is accepted.
- R6: The buffer holds DEPTH (4) entries and drains them oldest first. When it is full, st_ready_o is low, unless the store is a normal store that can merge into the newest entry.
- R7: While bar_req_i is high, st_ready_o is low. bar_done_o is a one-cycle pulse, raised on the clock edge after the buffer becomes empty. That is one cycle after the last bus write is accepted, or one cycle after the request if the buffer is already empty.
- R8: A lone open entry raises bus_valid_o only once HOLD_CYC (4) clock edges have passed since it was last written.
- R9: After reset the buffer is empty: st_ready_o is high, and bus_valid_o, bar_done_o and lkp_hit_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request |
| st_addr_i | input | ADDR_W | Store byte address; low 3 bits ignored |
| st_strb_i | input | 8 | Store lane strobe |
| st_data_i | input | 64 | Store data, lane aligned |
| st_so_i | input | 1 | Store targets a strongly ordered region |
| st_ready_o | output | 1 | Store accepted this cycle when high with st_valid_i |
| lkp_addr_i | input | ADDR_W | Read lookup byte address |
| lkp_hit_o | output | 8 | Lanes held in the buffer |
| lkp_data_o | output | 64 | Newest buffered data per hit lane |
| bar_req_i | input | 1 | Barrier request, held until completion |
| bar_done_o | output | 1 | Barrier completion pulse |
| bus_valid_o | output | 1 | Bus write request |
| bus_ready_i | input | 1 | Bus accepts the write |
| bus_addr_o | output | ADDR_W | Bus write block address |
| bus_strb_o | output | 8 | Bus write lane strobe |
| bus_data_o | output | 64 | Bus write data |

## Verification
A broken queue pointer or a lost merge shows up in the lookup port in the very next cycle. A lane that the bus has not yet written, but that the buffer no longer reports as held, is a dropped byte. A wrong override order shows up the same way, as a held lane whose data differs from the newest store. Ordering faults show up in the sequence of bus writes. The bench therefore checks the lookup port every cycle against a store image and a bus image, and compares the two images in full after each barrier.

// File: rtl/swb_pkg.sv
package swb_pkg;
  localparam int unsigned LANES  = 8;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = LANES * LANE_W;
  localparam int unsigned OFF_W  = $clog2(LANES);

  typedef logic [LANES-1:0]  strb_t;
  typedef logic [WORD_W-1:0] word_t;

  // newer lanes selected by sel replace older ones
  function automatic word_t lane_merge(word_t old_w, word_t new_w, strb_t sel);
    word_t r;
    r = old_w;
    for (int i = 0; i < int'(LANES); i++) begin
      if (sel[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    end
    return r;
  endfunction
endpackage

// File: rtl/swb_store_q.sv
module swb_store_q
  import swb_pkg::*;
#(
  parameter int unsigned BLK_W = 29,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             merge_i,
  input  logic             pop_i,
  input  logic [BLK_W-1:0] in_blk_i,
  input  strb_t            in_strb_i,
  input  word_t            in_data_i,
  input  logic             in_so_i,
  output logic [BLK_W-1:0] ent_blk_o  [DEPTH],
  output strb_t            ent_strb_o [DEPTH],
  output word_t            ent_data_o [DEPTH],
  output logic             ent_so_o   [DEPTH],
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o
);

  logic [PTR_W-1:0] head_q, wr_q, tail;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign tail = (wr_q == '0) ? PTR_W'(DEPTH - 1) : wr_q - 1'b1;

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_ent
    logic [BLK_W-1:0] blk_q;
    strb_t            strb_q;
    word_t            data_q;
    logic             so_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        blk_q  <= '0;
        strb_q <= '0;
        data_q <= '0;
        so_q   <= 1'b0;
      end else if (push_i && wr_q == PTR_W'(g)) begin
        blk_q  <= in_blk_i;
        strb_q <= in_strb_i;
        data_q <= in_data_i;
        so_q   <= in_so_i;
      end else if (merge_i && tail == PTR_W'(g)) begin
        strb_q <= strb_q | in_strb_i;
        data_q <= lane_merge(data_q, in_data_i, in_strb_i);
      end
    end

    assign ent_blk_o[g]  = blk_q;
    assign ent_strb_o[g] = strb_q;
    assign ent_data_o[g] = data_q;
    assign ent_so_o[g]   = so_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      wr_q    <= '0;
      count_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i) head_q <= nxt(head_q);
      count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail;
  assign count_o = count_q;

  // R6
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_q) <= int'(DEPTH));
  // R6
  no_push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(count_q) == int'(DEPTH) && !pop_i) |-> !push_i);
  // R3
  no_pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0) |-> !(pop_i || merge_i));
endmodule

// File: rtl/swb_fwd.sv
module swb_fwd
  import swb_pkg::*;
#(
  parameter int unsigned BLK_W = 29,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BLK_W-1:0] ent_blk_i  [DEPTH],
  input  strb_t            ent_strb_i [DEPTH],
  input  word_t            ent_data_i [DEPTH],
  input  logic [PTR_W-1:0] head_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [BLK_W-1:0] lkp_blk_i,
  output strb_t            hit_o,
  output word_t            data_o
);

  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_cmp
    assign match[g] = (ent_blk_i[g] == lkp_blk_i);
  end

  // walk oldest to newest so the newest lane wins
  always_comb begin
    hit_o  = '0;
    data_o = '0;
    for (int k = 0; k < int'(DEPTH); k++) begin
      int idx;
      idx = int'(head_i) + k;
      if (idx >= int'(DEPTH)) idx = idx - int'(DEPTH);
      if (k < int'(count_i) && match[idx]) begin
        hit_o  = hit_o | ent_strb_i[idx];
        data_o = lane_merge(data_o, ent_data_i[idx], ent_strb_i[idx]);
      end
    end
  end

  // R4
  hit_needs_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o != '0) |-> (count_i != '0));
endmodule

// File: rtl/swb_drain.sv
module swb_drain #(
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned HOLD_CYC = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned AGE_W = $clog2(HOLD_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             head_so_i,
  input  logic             touch_i,
  input  logic             bar_req_i,
  input  logic             bus_ready_i,
  output logic             bus_valid_o,
  output logic             bar_done_o
);

  logic [AGE_W-1:0] age_q;
  logic             issue_q, done_q, want;

  // a lone open entry waits for merges; anything else goes now
  assign want = (count_i > CNT_W'(1)) || head_so_i || bar_req_i ||
                (age_q == AGE_W'(HOLD_CYC));
  assign bus_valid_o = (count_i != '0) && (issue_q || want);
  assign bar_done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q   <= '0;
      issue_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (touch_i) age_q <= '0;
      else if (age_q != AGE_W'(HOLD_CYC)) age_q <= age_q + 1'b1;
      issue_q <= bus_valid_o && !bus_ready_i;
      done_q  <= bar_req_i && (count_i == '0) && !done_q;
    end
  end

  // R1
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_ready_i) |=> bus_valid_o);
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bar_done_o |=> !bar_done_o);
endmodule

// File: rtl/store_merge_buf.sv
module store_merge_buf
  import swb_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned HOLD_CYC = 4,
  localparam int unsigned BLK_W = ADDR_W - OFF_W,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [7:0]        st_strb_i,
  input  logic [63:0]       st_data_i,
  input  logic              st_so_i,
  output logic              st_ready_o,
  input  logic [ADDR_W-1:0] lkp_addr_i,
  output logic [7:0]        lkp_hit_o,
  output logic [63:0]       lkp_data_o,
  input  logic              bar_req_i,
  output logic              bar_done_o,
  output logic              bus_valid_o,
  input  logic              bus_ready_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_strb_o,
  output logic [63:0]       bus_data_o
);

  logic [BLK_W-1:0] ent_blk  [DEPTH];
  strb_t            ent_strb [DEPTH];
  word_t            ent_data [DEPTH];
  logic             ent_so   [DEPTH];
  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] cnt;
  logic [BLK_W-1:0] st_blk;
  logic             full, merge_ok, acc, merge, push, pop;

  assign st_blk = st_addr_i[ADDR_W-1:OFF_W];
  assign full   = (cnt == CNT_W'(DEPTH));

  // the newest entry is closed when strongly ordered or already offered alone
  assign merge_ok = (cnt != '0) && !ent_so[tail] && (ent_blk[tail] == st_blk) &&
                    !((cnt == CNT_W'(1)) && bus_valid_o);

  assign st_ready_o = !bar_req_i && (!full || (merge_ok && !st_so_i));
  assign acc   = st_valid_i && st_ready_o;
  assign merge = acc && !st_so_i && merge_ok;
  assign push  = acc && !merge;
  assign pop   = bus_valid_o && bus_ready_i;

  swb_store_q #(.BLK_W(BLK_W), .DEPTH(DEPTH)) i_store_q (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .merge_i    (merge),
    .pop_i      (pop),
    .in_blk_i   (st_blk),
    .in_strb_i  (st_strb_i),
    .in_data_i  (st_data_i),
    .in_so_i    (st_so_i),
    .ent_blk_o  (ent_blk),
    .ent_strb_o (ent_strb),
    .ent_data_o (ent_data),
    .ent_so_o   (ent_so),
    .head_o     (head),
    .tail_o     (tail),
    .count_o    (cnt)
  );

  swb_fwd #(.BLK_W(BLK_W), .DEPTH(DEPTH)) i_fwd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ent_blk_i  (ent_blk),
    .ent_strb_i (ent_strb),
    .ent_data_i (ent_data),
    .head_i     (head),
    .count_i    (cnt),
    .lkp_blk_i  (lkp_addr_i[ADDR_W-1:OFF_W]),
    .hit_o      (lkp_hit_o),
    .data_o     (lkp_data_o)
  );

  swb_drain #(.DEPTH(DEPTH), .HOLD_CYC(HOLD_CYC)) i_drain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .count_i     (cnt),
    .head_so_i   (ent_so[head]),
    .touch_i     (acc),
    .bar_req_i   (bar_req_i),
    .bus_ready_i (bus_ready_i),
    .bus_valid_o (bus_valid_o),
    .bar_done_o  (bar_done_o)
  );

  assign bus_addr_o = {ent_blk[head], OFF_W'(0)};
  assign bus_strb_o = ent_strb[head];
  assign bus_data_o = ent_data[head];

  // R1
  payload_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_ready_i) |=>
      ($stable(bus_addr_o) && $stable(bus_strb_o) && $stable(bus_data_o)));
  // R5
  so_new_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && st_so_i && st_ready_o) |=>
      (int'(cnt) == int'($past(cnt)) + 1 - int'($past(pop))));
endmodule

// File: tb/test_store_merge_buf.sv
module test_store_merge_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0, st_so = 1'b0, bar_req = 1'b0, bus_ready = 1'b0;
  logic [31:0] st_addr = '0, lkp_addr = '0;
  logic [7:0]  st_strb = '0;
  logic [63:0] st_data = '0;
  logic        st_ready, bar_done, bus_valid;
  logic [7:0]  lkp_hit, bus_strb;
  logic [63:0] lkp_data, bus_data;
  logic [31:0] bus_addr;

  always #5 clk = ~clk;

  store_merge_buf i_store_merge_buf (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_strb_i(st_strb),
    .st_data_i(st_data), .st_so_i(st_so), .st_ready_o(st_ready),
    .lkp_addr_i(lkp_addr), .lkp_hit_o(lkp_hit), .lkp_data_o(lkp_data),
    .bar_req_i(bar_req), .bar_done_o(bar_done),
    .bus_valid_o(bus_valid), .bus_ready_i(bus_ready),
    .bus_addr_o(bus_addr), .bus_strb_o(bus_strb), .bus_data_o(bus_data)
  );

  int total = 0, bad = 0, stepn = 0, last_bus = -10, log_n = 0;
  logic [7:0]  cpu_img [128];
  logic [7:0]  bus_mem [128];
  logic [3:0]  log_blk [64];
  logic [7:0]  log_strb[64];
  logic [63:0] log_data[64];
  logic sv_valid, sv_done, acc;
  int cur;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit lkp_ok(output logic [63:0] expd);
    bit ok = 1'b1;
    int b = int'(lkp_addr[6:3]);
    expd = '0;
    for (int j = 0; j < 8; j++) begin
      expd[j*8 +: 8] = cpu_img[b*8+j];
      if (lkp_hit[j]) begin
        if (lkp_data[j*8 +: 8] !== cpu_img[b*8+j]) ok = 1'b0;
      end else if (bus_mem[b*8+j] !== cpu_img[b*8+j]) ok = 1'b0;
    end
    return ok;
  endfunction

  task automatic cyc(input logic v, input logic so, input logic [3:0] blk,
                     input logic [7:0] sb, input logic [63:0] d,
                     input logic rdy, input logic bar);
    logic [63:0] e;
    @(negedge clk);
    sv_valid = bus_valid;
    sv_done  = bar_done;
    chk(lkp_ok(e), "R4", "lookup lanes vs store/bus images", lkp_data, e);
    st_valid = v; st_so = so; st_addr = {25'd0, blk, 3'($urandom % 8)};
    st_strb = sb; st_data = d; bus_ready = rdy; bar_req = bar;
    lkp_addr = {25'd0, 4'($urandom % 16), 3'd0};
    #1;
    acc = st_valid && st_ready;
    if (acc)
      for (int j = 0; j < 8; j++) if (sb[j]) cpu_img[blk*8+j] = d[j*8 +: 8];
    if (bus_valid && bus_ready) begin
      for (int j = 0; j < 8; j++)
        if (bus_strb[j]) bus_mem[int'(bus_addr[6:3])*8+j] = bus_data[j*8 +: 8];
      if (log_n < 64) begin
        log_blk[log_n] = bus_addr[6:3];
        log_strb[log_n] = bus_strb;
        log_data[log_n] = bus_data;
      end
      log_n++;
      last_bus = stepn;
    end
    cur = stepn;
    stepn++;
  endtask

  task automatic idle(input logic rdy);
    cyc(1'b0, 1'b0, 4'd0, 8'd0, 64'd0, rdy, 1'b0);
  endtask

  task automatic barrier();
    int start, exp_step, got = -1;
    bit stalled = 1'b1;
    start = stepn;
    for (int i = 0; i < 60 && got < 0; i++) begin
      cyc(1'b1, 1'b0, 4'($urandom % 16), 8'hFF, {$urandom, $urandom},
          1'($urandom % 2), 1'b1);
      if (acc) stalled = 1'b0;
      if (sv_done) got = cur;
    end
    idle(1'b1);
    exp_step = (last_bus + 2 > start + 1) ? last_bus + 2 : start + 1;
    chk(stalled, "R7", "store accepted during barrier", 64'(stalled), 64'd1);
    chk(got == exp_step, "R7", "barrier done step", 64'(got), 64'(exp_step));
    begin
      bit same = 1'b1;
      for (int i = 0; i < 128; i++) if (cpu_img[i] !== bus_mem[i]) same = 1'b0;
      chk(same, "R3", "bus image equals store image", 64'(same), 64'd1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=done", stepn);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s, seed;
    seed = $urandom(32'd7321);
    for (int i = 0; i < 128; i++) begin cpu_img[i] = 8'h00; bus_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    chk(st_ready === 1'b1, "R9", "ready after reset", 64'(st_ready), 64'd1);
    chk(bus_valid === 1'b0, "R9", "bus_valid after reset", 64'(bus_valid), 64'd0);
    chk(bar_done === 1'b0, "R9", "bar_done after reset", 64'(bar_done), 64'd0);
    chk(lkp_hit === 8'h00, "R9", "hit mask after reset", 64'(lkp_hit), 64'd0);

    // R2 four byte stores plus an override into one write
    log_n = 0;
    cyc(1, 0, 4'd2, 8'h01, 64'h11, 0, 0);
    cyc(1, 0, 4'd2, 8'h02, 64'h2200, 0, 0);
    cyc(1, 0, 4'd2, 8'h04, 64'h330000, 0, 0);
    cyc(1, 0, 4'd2, 8'h08, 64'h44000000, 0, 0);
    cyc(1, 0, 4'd2, 8'h01, 64'h55, 0, 0);
    repeat (8) idle(1'b1);
    chk(log_n == 1, "R2", "bus writes for merged block", 64'(log_n), 64'd1);
    chk(log_strb[0] == 8'h0F, "R2", "merged strobe", 64'(log_strb[0]), 64'h0F);
    chk(log_data[0][31:0] == 32'h44332255, "R2", "merged data",
        64'(log_data[0][31:0]), 64'h44332255);

    // R5 strongly ordered store keeps its own entry and its place
    log_n = 0;
    cyc(1, 0, 4'd3, 8'h01, 64'hAA, 0, 0);
    cyc(1, 1, 4'd3, 8'h02, 64'hBB00, 0, 0);
    cyc(1, 0, 4'd3, 8'h04, 64'hCC0000, 0, 0);
    repeat (6) idle(1'b1);
    chk(log_n == 3, "R5", "separate writes around ordered store", 64'(log_n), 64'd3);
    chk({log_strb[0], log_strb[1], log_strb[2]} == 24'h010204, "R5",
        "program order of strobes", 64'({log_strb[0], log_strb[1], log_strb[2]}),
        64'h010204);
    cyc(1, 1, 4'd10, 8'h10, 64'h77_0000_0000, 0, 0);
    idle(1'b0);
    chk(sv_valid === 1'b1, "R5", "ordered lone entry issued next cycle",
        64'(sv_valid), 64'd1);
    repeat (3) idle(1'b1);

    // R6 full queue stalls, merge still allowed, oldest first
    log_n = 0;
    for (int b = 4; b < 8; b++) cyc(1, 0, 4'(b), 8'h01, 64'(b), 0, 0);
    cyc(1, 0, 4'd8, 8'h01, 64'h9, 0, 0);
    chk(acc === 1'b0, "R6", "store to new block when full", 64'(acc), 64'd0);
    cyc(1, 0, 4'd7, 8'h80, 64'h5A00_0000_0000_0000, 0, 0);
    chk(acc === 1'b1, "R6", "merge into newest when full", 64'(acc), 64'd1);
    repeat (10) idle(1'b1);
    chk(log_n == 4, "R6", "write count after full test", 64'(log_n), 64'd4);
    chk({log_blk[0], log_blk[1], log_blk[2], log_blk[3]} == 16'h4567, "R6",
        "drain order", 64'({log_blk[0], log_blk[1], log_blk[2], log_blk[3]}), 64'h4567);
    chk(log_strb[3] == 8'h81, "R2", "strobe OR of merged tail", 64'(log_strb[3]), 64'h81);

    // R8 hold window of a lone open entry
    cyc(1, 0, 4'd9, 8'h03, 64'h1234, 1, 0);
    s = 0;
    for (int k = 1; k <= 4; k++) begin idle(1'b1); if (sv_valid) s++; end
    chk(s == 0, "R8", "early issue of lone entry", 64'(s), 64'd0);
    idle(1'b1);
    chk(sv_valid === 1'b1, "R8", "issue after hold window", 64'(sv_valid), 64'd1);
    repeat (2) idle(1'b1);

    // R7 barrier on an empty buffer and with pending work
    barrier();
    for (int i = 0; i < 3; i++)
      cyc(1, 0, 4'(i + 11), 8'hF0, {$urandom, $urandom}, 0, 0);
    barrier();

    // random mix
    for (int r = 0; r < 4000; r++) begin
      cyc(1'($urandom % 4 != 0), 1'($urandom % 8 == 0), 4'($urandom % 6),
          8'($urandom % 255 + 1), {$urandom, $urandom}, 1'($urandom % 3 != 0), 0);
      if (r % 500 == 499) barrier();
    end
    barrier();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule